// File: doc/BRIEF.md
# Power Domain Power-On Sequencer

This block takes one gated power domain from fully off to fully on without software stepping each bit. Once a unlock word has been written, a start pulse launches a fixed ordering over a seven-bit power-control word. The switch is driven in two stages, and the block waits for both status acknowledges. The domain clock is then ungated, isolation is lifted and reset is released. After that, SRAM banks chosen by a mask are powered and their acknowledges awaited. When the SRAM-isolation capability strap is set, a timed release of the SRAM isolation pair ends the run.

The control word drives the power switch, isolation cells and reset of the domain, and the SRAM power-down vector goes to the macro banks. A controller reads `busy_o` and `done_o` to follow progress. Each acknowledge wait has a bounded timeout. A timeout sets a sticky error flag and drops the block back to idle with the sequence unfinished.

Top module: `pd_pwron_seq`

## Requirements
- R1: A start request is ignored until a write on the unlock port has carried the key in bits 31:16 and a 1 in bit 0. A write with a wrong key, or with bit 0 clear, does not unlock.
- R2: After reset `ctrl_o` = 7'b0110010, `sram_pdn_o` is all ones, and `busy_o`, `done_o` and `err_o` are low. The bit positions are: 0 reset release (active high = out of reset), 1 isolation, 2 power-on, 3 second power-on, 4 clock disable, 5 SRAM clock isolation, 6 SRAM internal isolation release.
- R3: Two cycles after an accepted start, power-on (bit 2) goes high. Second power-on (bit 3) follows in the next cycle.
- R4: Clock disable (bit 4) stays high until both `pwr_ack_i` and `pwr_ack2_i` are high. It clears two cycles after the first cycle in which both are seen high.
- R5: Isolation (bit 1) clears the cycle after clock disable clears. Reset release (bit 0) sets the cycle after that.
- R6: One cycle after reset release, exactly the `sram_pdn_o` bits selected by `sram_pdn_mask_i` are cleared. Unselected bits stay set, and no SRAM power-down bit ever rises outside reset.
- R7: The block then waits until every `sram_ack_i` bit selected by `sram_ack_mask_i` is zero. Unselected acknowledge bits have no effect.
- R8: With `sram_iso_cap_i` high, SRAM internal isolation release (bit 6) sets two cycles after the SRAM acks are seen clear. SRAM clock isolation (bit 5) clears CLK_FREQ_MHZ+1 cycles later, which is never sooner than CLK_FREQ_MHZ cycles.
- R9: With `sram_iso_cap_i` low, bits 5 and 6 keep their reset values for the whole run.
- R10: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `done_o` is a single-cycle pulse, and a start while busy is ignored.
- R11: If an acknowledge wait lasts ACK_TIMEOUT cycles, `err_o` sets and stays set until reset. `busy_o` then drops without a `done_o` pulse, and the remaining steps are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unlock_we_i | input | 1 | Unlock register write strobe |
| unlock_wdata_i | input | 32 | Unlock write data: key in 31:16, enable in bit 0 |
| start_i | input | 1 | Start request |
| sram_iso_cap_i | input | 1 | Capability strap for SRAM isolation release |
| pwr_ack_i | input | 1 | Primary power-switch status acknowledge |
| pwr_ack2_i | input | 1 | Secondary power-switch status acknowledge |
| sram_ack_i | input | SRAM_W | SRAM power-down acknowledges |
| sram_pdn_mask_i | input | SRAM_W | SRAM banks to power up |
| sram_ack_mask_i | input | SRAM_W | SRAM acknowledges to wait on |
| ctrl_o | output | 7 | Power-control word |
| sram_pdn_o | output | SRAM_W | SRAM power-down vector |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The assertions assume that the capability strap and both masks stay stable during a run. They also assume that the power acknowledges, once raised, stay high until the clock-disable release: the ordering check looks back two cycles at those inputs. The bench respects this in every run. It raises the primary acknowledge at or before the secondary and holds both high. It sets the strap and masks before the start pulse, and it only changes them after a reset. The acknowledge delays are drawn well inside the timeout window, so that only the dedicated timeout case reaches the error path.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int CTRL_W    = 7;
  localparam int CB_RST_N  = 0;
  localparam int CB_ISO    = 1;
  localparam int CB_PON    = 2;
  localparam int CB_PON2   = 3;
  localparam int CB_CLKDIS = 4;
  localparam int CB_SCKISO = 5;
  localparam int CB_SISO_N = 6;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 7'b0110010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PON, ST_PON2, ST_WAIT_PWR, ST_CLK_ON, ST_ISO_OFF, ST_RST_REL,
    ST_SRAM_ON, ST_WAIT_SRAM, ST_SISO_REL, ST_SDLY, ST_SCK_REL, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/pd_seq_unlock.sv
module pd_seq_unlock #(
  parameter logic [15:0] KEY = 16'h5A3C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic        unlocked_o
);
  logic unlocked_q;
  logic key_hit;
  logic unused_mid;

  assign key_hit    = we_i && (wdata_i[31:16] == KEY) && wdata_i[0];
  assign unused_mid = ^wdata_i[15:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unlocked_q <= 1'b0;
    else if (key_hit) unlocked_q <= 1'b1;
  end

  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/pd_seq_timer.sv
module pd_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int          SRAM_W   = 4,
  parameter int          CNT_W    = 8,
  parameter int unsigned DLY_LOAD = 0,
  parameter int unsigned TMO_LOAD = 0,
  parameter bit          TMO_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unlocked_i,
  input  logic              start_i,
  input  logic              cap_i,
  input  logic              ack1_i,
  input  logic              ack2_i,
  input  logic [SRAM_W-1:0] sram_ack_i,
  input  logic [SRAM_W-1:0] pdn_mask_i,
  input  logic [SRAM_W-1:0] ack_mask_i,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              tmr_dec_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [SRAM_W-1:0] sram_pdn_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e        st_q, st_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [SRAM_W-1:0] pdn_q, pdn_d;
  logic              err_q, err_d;
  logic              tmo_hit;
  logic              pwr_ok;
  logic              sram_ok;

  generate
    if (TMO_EN) begin : g_tmo
      assign tmo_hit = tmr_zero_i;
    end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
    end
  endgenerate

  assign pwr_ok  = ack1_i & ack2_i;
  assign sram_ok = ~|(sram_ack_i & ack_mask_i);

  always_comb begin
    st_d       = st_q;
    ctrl_d     = ctrl_q;
    pdn_d      = pdn_q;
    err_d      = err_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = CNT_W'(TMO_LOAD);
    tmr_dec_o  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (unlocked_i && start_i) st_d = ST_PON;
      ST_PON: begin
        ctrl_d[CB_PON] = 1'b1;
        st_d = ST_PON2;
      end
      ST_PON2: begin
        ctrl_d[CB_PON2] = 1'b1;
        tmr_load_o = 1'b1;
        st_d = ST_WAIT_PWR;
      end
      ST_WAIT_PWR: begin
        tmr_dec_o = 1'b1;
        if (pwr_ok) st_d = ST_CLK_ON;
        else if (tmo_hit) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_CLK_ON: begin
        ctrl_d[CB_CLKDIS] = 1'b0;
        st_d = ST_ISO_OFF;
      end
      ST_ISO_OFF: begin
        ctrl_d[CB_ISO] = 1'b0;
        st_d = ST_RST_REL;
      end
      ST_RST_REL: begin
        ctrl_d[CB_RST_N] = 1'b1;
        st_d = ST_SRAM_ON;
      end
      ST_SRAM_ON: begin
        pdn_d = pdn_q & ~pdn_mask_i;
        tmr_load_o = 1'b1;
        st_d = ST_WAIT_SRAM;
      end
      ST_WAIT_SRAM: begin
        tmr_dec_o = 1'b1;
        if (sram_ok) st_d = cap_i ? ST_SISO_REL : ST_FIN;
        else if (tmo_hit) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_SISO_REL: begin
        ctrl_d[CB_SISO_N] = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(DLY_LOAD);
        st_d = ST_SDLY;
      end
      ST_SDLY: begin
        tmr_dec_o = 1'b1;
        if (tmr_zero_i) st_d = ST_SCK_REL;
      end
      ST_SCK_REL: begin
        ctrl_d[CB_SCKISO] = 1'b0;
        st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ctrl_q <= CTRL_RESET;
      pdn_q  <= '1;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctrl_q <= ctrl_d;
      pdn_q  <= pdn_d;
      err_q  <= err_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign sram_pdn_o = pdn_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);
  assign err_o      = err_q;
endmodule

// File: rtl/pd_pwron_seq.sv
module pd_pwron_seq
  import pd_seq_pkg::*;
#(
  parameter int          SRAM_W       = 4,
  parameter int unsigned CLK_FREQ_MHZ = 50,
  parameter int unsigned ACK_TIMEOUT  = 4096,
  parameter logic [15:0] UNLOCK_KEY   = 16'h5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unlock_we_i,
  input  logic [31:0]       unlock_wdata_i,
  input  logic              start_i,
  input  logic              sram_iso_cap_i,
  input  logic              pwr_ack_i,
  input  logic              pwr_ack2_i,
  input  logic [SRAM_W-1:0] sram_ack_i,
  input  logic [SRAM_W-1:0] sram_pdn_mask_i,
  input  logic [SRAM_W-1:0] sram_ack_mask_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [SRAM_W-1:0] sram_pdn_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned MAX_CYC  = (ACK_TIMEOUT > CLK_FREQ_MHZ) ? ACK_TIMEOUT : CLK_FREQ_MHZ;
  localparam int          CNT_W    = $clog2(MAX_CYC + 1);
  localparam int unsigned DLY_LOAD = (CLK_FREQ_MHZ > 0) ? CLK_FREQ_MHZ - 1 : 0;
  localparam int unsigned TMO_LOAD = (ACK_TIMEOUT > 0) ? ACK_TIMEOUT - 1 : 0;
  localparam bit          TMO_EN   = (ACK_TIMEOUT > 0);

  logic             unlocked;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_dec;
  logic             tmr_zero;

  pd_seq_unlock #(.KEY(UNLOCK_KEY)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (unlock_we_i),
    .wdata_i   (unlock_wdata_i),
    .unlocked_o(unlocked)
  );

  pd_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .dec_i     (tmr_dec),
    .zero_o    (tmr_zero)
  );

  pd_seq_fsm #(
    .SRAM_W  (SRAM_W),
    .CNT_W   (CNT_W),
    .DLY_LOAD(DLY_LOAD),
    .TMO_LOAD(TMO_LOAD),
    .TMO_EN  (TMO_EN)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unlocked_i(unlocked),
    .start_i   (start_i),
    .cap_i     (sram_iso_cap_i),
    .ack1_i    (pwr_ack_i),
    .ack2_i    (pwr_ack2_i),
    .sram_ack_i(sram_ack_i),
    .pdn_mask_i(sram_pdn_mask_i),
    .ack_mask_i(sram_ack_mask_i),
    .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .tmr_dec_o (tmr_dec),
    .ctrl_o    (ctrl_o),
    .sram_pdn_o(sram_pdn_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/pd_pwron_seq_chk.sv
module pd_pwron_seq_chk #(
  parameter int          SRAM_W       = 4,
  parameter int unsigned CLK_FREQ_MHZ = 50,
  parameter logic [15:0] UNLOCK_KEY   = 16'h5A3C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              unlock_we_i,
  input logic [15:0]       key_i,
  input logic              en_bit_i,
  input logic              pwr_ack_i,
  input logic              pwr_ack2_i,
  input logic [6:0]        ctrl_o,
  input logic [SRAM_W-1:0] sram_pdn_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int CW = $clog2(CLK_FREQ_MHZ + 2) + 1;

  logic          seen_q;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (unlock_we_i && key_i == UNLOCK_KEY && en_bit_i) seen_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (!ctrl_o[6]) hi_cnt <= '0;
    else if (!(&hi_cnt)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_START_AFTER_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> seen_q); // R1
  AST_PON2_AFTER_PON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[3]) |-> $past(ctrl_o[2])); // R3
  AST_CLK_AFTER_ACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[4]) |-> $past(pwr_ack_i && pwr_ack2_i, 2)); // R4
  AST_ISO_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[1]) |-> !ctrl_o[4]); // R5
  AST_RST_AFTER_ISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[0]) |-> !ctrl_o[1]); // R5
  AST_PDN_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_pdn_o & ~$past(sram_pdn_o)) == '0); // R6
  AST_CKISO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[5]) |-> hi_cnt >= CW'(CLK_FREQ_MHZ)); // R8
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11
endmodule

bind pd_pwron_seq pd_pwron_seq_chk #(
  .SRAM_W      (SRAM_W),
  .CLK_FREQ_MHZ(CLK_FREQ_MHZ),
  .UNLOCK_KEY  (UNLOCK_KEY)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .unlock_we_i(unlock_we_i),
  .key_i      (unlock_wdata_i[31:16]),
  .en_bit_i   (unlock_wdata_i[0]),
  .pwr_ack_i  (pwr_ack_i),
  .pwr_ack2_i (pwr_ack2_i),
  .ctrl_o     (ctrl_o),
  .sram_pdn_o (sram_pdn_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/pd_pwron_seq_tb.sv
module pd_pwron_seq_tb;
  localparam int SW  = 4;
  localparam int NUS = 8;
  localparam int TMO = 40;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          unlock_we_i = 1'b0;
  logic [31:0]   unlock_wdata_i = '0;
  logic          start_i = 1'b0;
  logic          sram_iso_cap_i = 1'b0;
  logic          pwr_ack_i = 1'b0;
  logic          pwr_ack2_i = 1'b0;
  logic [SW-1:0] sram_ack_i = '1;
  logic [SW-1:0] sram_pdn_mask_i = '0;
  logic [SW-1:0] sram_ack_mask_i = '0;
  logic [6:0]    ctrl_o;
  logic [SW-1:0] sram_pdn_o;
  logic          busy_o, done_o, err_o;

  int n_chk = 0;
  int n_fail = 0;

  pd_pwron_seq #(.SRAM_W(SW), .CLK_FREQ_MHZ(NUS), .ACK_TIMEOUT(TMO), .UNLOCK_KEY(KEY)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .unlock_we_i(unlock_we_i), .unlock_wdata_i(unlock_wdata_i),
    .start_i(start_i), .sram_iso_cap_i(sram_iso_cap_i), .pwr_ack_i(pwr_ack_i),
    .pwr_ack2_i(pwr_ack2_i), .sram_ack_i(sram_ack_i), .sram_pdn_mask_i(sram_pdn_mask_i),
    .sram_ack_mask_i(sram_ack_mask_i), .ctrl_o(ctrl_o), .sram_pdn_o(sram_pdn_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_ctrl(int c, int a, int s, bit cap);
    logic [6:0] v = 7'b0110010;
    if (c >= 2) v[2] = 1'b1;
    if (c >= 3) v[3] = 1'b1;
    if (c >= a + 2) v[4] = 1'b0;
    if (c >= a + 3) v[1] = 1'b0;
    if (c >= a + 4) v[0] = 1'b1;
    if (cap && c >= s + 2) v[6] = 1'b1;
    if (cap && c >= s + NUS + 3) v[5] = 1'b0;
    return v;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; start_i = 1'b0; unlock_we_i = 1'b0; pwr_ack_i = 1'b0; pwr_ack2_i = 1'b0;
    sram_ack_i = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic unlock_wr(logic [31:0] d);
    unlock_we_i = 1'b1; unlock_wdata_i = d;
    @(negedge clk_i);
    unlock_we_i = 1'b0; unlock_wdata_i = '0;
  endtask

  task automatic probe_ignored(string tag);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(tag, {31'd0, busy_o}, 32'd0);
    @(negedge clk_i);
    chk(tag, {31'd0, busy_o}, 32'd0);
  endtask

  // a1: primary ack cycle, a: secondary ack cycle, s: masked SRAM acks drop
  task automatic run_seq(int a1, int a, int s, bit cap, logic [SW-1:0] pm, logic [SW-1:0] am, int mid);
    int seff, done_c;
    logic [6:0] ec;
    seff   = (am == '0) ? a + 5 : ((s > a + 5) ? s : a + 5);
    done_c = cap ? seff + NUS + 3 : seff + 1;
    sram_iso_cap_i = cap; sram_pdn_mask_i = pm; sram_ack_mask_i = am;
    start_i = 1'b1;
    for (int c = 1; c <= done_c + 2; c++) begin
      @(negedge clk_i);
      start_i    = (c == mid);
      pwr_ack_i  = (c >= a1);
      pwr_ack2_i = (c >= a);
      sram_ack_i = (c >= s) ? ~am : '1;
      ec = exp_ctrl(c, a, seff, cap);
      if (c == 1) chk("R1 start accepted after unlock", {31'd0, busy_o}, 32'd1);
      chk("R3 power-on order", {30'd0, ctrl_o[3:2]}, {30'd0, ec[3:2]});
      chk("R4 clock disable waits both acks", {31'd0, ctrl_o[4]}, {31'd0, ec[4]});
      chk("R5 isolation/reset order", {30'd0, ctrl_o[1:0]}, {30'd0, ec[1:0]});
      chk("R6 SRAM power-down", {28'd0, sram_pdn_o}, {28'd0, (c >= a + 5) ? ~pm : {SW{1'b1}}});
      if (cap) chk("R8 SRAM isolation release", {30'd0, ctrl_o[6:5]}, {30'd0, ec[6:5]});
      else     chk("R9 SRAM isolation untouched", {30'd0, ctrl_o[6:5]}, 32'd1);
      chk("R10 busy/done", {30'd0, busy_o, done_o}, {30'd0, (c <= done_c), (c == done_c)});
      chk("R11 no error", {31'd0, err_o}, 32'd0);
      if (c == seff)
        chk("R7 still waiting on SRAM acks", {30'd0, busy_o, cap ? ctrl_o[6] : done_o}, 32'd2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    chk("R2 reset ctrl", {25'd0, ctrl_o}, 32'h32);
    chk("R2 reset sram_pdn", {28'd0, sram_pdn_o}, 32'hF);
    chk("R2 reset flags", {29'd0, busy_o, done_o, err_o}, 32'd0);

    probe_ignored("R1 start before unlock");
    unlock_wr({KEY ^ 16'h0001, 16'h0001});
    probe_ignored("R1 wrong key");
    unlock_wr({KEY, 16'h0000});
    probe_ignored("R1 enable bit clear");
    unlock_wr({KEY, 16'h0001});

    // directed: quickest path, no SRAM waits, no capability
    run_seq(3, 3, 0, 1'b0, 4'b0000, 4'b0000, 0);
    // directed: full masks, capability on, start while busy
    do_reset(); unlock_wr({KEY, 16'h0001});
    run_seq(4, 9, 20, 1'b1, 4'b1111, 4'b1111, 6);

    for (int i = 0; i < 10; i++) begin
      int a, a1, s;
      do_reset(); unlock_wr({KEY, 16'h0001} | {16'd0, 16'($urandom_range(0, 255)) << 1});
      a  = 3 + $urandom_range(0, 20);
      a1 = a - $urandom_range(0, a - 3);
      s  = a + 5 + $urandom_range(0, 15);
      run_seq(a1, a, s, 1'($urandom_range(0, 1)), 4'($urandom), 4'($urandom), 4 + $urandom_range(0, 8));
    end

    // timeout on the power acknowledge wait
    do_reset(); unlock_wr({KEY, 16'h0001});
    sram_iso_cap_i = 1'b1;
    start_i = 1'b1;
    for (int c = 1; c <= TMO + 6; c++) begin
      @(negedge clk_i);
      start_i   = 1'b0;
      pwr_ack_i = 1'b1;
      chk("R11 busy until timeout", {31'd0, busy_o}, {31'd0, c <= 2 + TMO});
      chk("R11 error flag", {31'd0, err_o}, {31'd0, c >= 3 + TMO});
      chk("R11 no done on timeout", {31'd0, done_o}, 32'd0);
      chk("R11 clock stays disabled", {31'd0, ctrl_o[4]}, 32'd1);
    end
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R11 error sticky across restart", {31'd0, err_o}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule